// File: doc/BRIEF.md
# Link Test-Mode Configuration Controller

This block holds the test-mode setup of a two-lane serial link device and decides when each written value starts to act. Software-side logic writes three kinds of byte through one write port: a mode code, a parameter byte and a sub-mode byte. A two-bit link-state input reports whether the link is Active, Dormant or in Re-Sync. Out of these the block keeps the effective sub-mode and its class (normal or disconnect), a flag saying whether Dormant entry is still permitted, the effective PLL multiplier select, the loop-back direction and one transmit enable per lane.

Some settings act on the clock edge that takes the write. Others wait in a pending register until the link leaves Dormant, or leaves either Dormant or Re-Sync. An "exit" is a cycle where the link-state input no longer shows a state that it showed in the cycle before. Pending values that were already held are applied on that exit edge before any write taken on the same edge, so a write on the exit edge is never applied at that exit.

The write port follows valid/ready rules. `wr_ready` is always high, so the block never applies back-pressure: every cycle with `wr_valid` high is a write. All outputs are registered and change on the clock edge that takes the write or sees the exit.

Top module: `lt_tmode_ctrl`

## Requirements
- R1: After reset: sub-mode 000, normal class (`disc_mode`=0), `dormant_ok`=1, multiplier code 000 (x15), forward loop-back (`lb_backward`=0), `lane_tx_en`=2'b10, and nothing pending.
- R2: A mode-code write of 8'h00 makes the staged sub-mode effective with normal class and `dormant_ok`=1 on the next clock edge, and drops any pending mode setting.
- R3: A mode-code write of 8'h01 sets `dormant_ok`=1 at once. It holds the staged sub-mode with normal class pending, and applies it on the first Dormant exit only. A Re-Sync exit does not apply it. Once applied, the pending value is cleared, so a later exit has no effect.
- R4: A mode-code write of 8'h02 makes the staged sub-mode effective with disconnect class and sets `dormant_ok`=0 on the next edge.
- R5: A mode-code write of 8'h03 sets `dormant_ok`=0 at once. It holds the staged sub-mode with disconnect class pending until the next Dormant exit.
- R6: A mode-code write above 8'h03 changes no output and no pending state.
- R7: A sub-mode byte write (`wr_addr`=2) stages bits 3:1 of `wr_data`. The other bits are ignored. Staging alone changes no output.
- R8: A parameter write (`wr_addr`=1) with bits 2:0 equal to 000 (x15) or 001 (x30) makes that code pending. `pll_mult_sel` takes it only on an exit from Dormant or from Re-Sync.
- R9: A parameter write with bits 2:0 in 010..111 leaves the multiplier, pending or effective, untouched.
- R10: Bit 7 of a parameter write is the loop-back direction: 0 is forward (lane 0 receive to lane 1 transmit), 1 is backward (lane 1 receive to lane 0 transmit). `lb_backward` follows it on the next edge. If the bit differs from the current direction, `lane_tx_en` becomes 2'b00 on that same edge. An equal bit changes nothing.
- R11: After a forced turnaround, both lanes stay input until the next exit from Dormant or Re-Sync. At that exit the transmit lane for the current direction is enabled: `lane_tx_en`=2'b10 when forward, 2'b01 when backward. At most one lane transmits at any time.
- R12: `wr_ready` is always 1. `wr_addr` selects 0 for the mode code, 1 for the parameter byte, 2 for the sub-mode byte and 3 for nothing; a write to address 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write acceptance, constant 1 |
| wr_addr | input | 2 | Write target: 0 mode code, 1 parameter, 2 sub-mode, 3 none |
| wr_data | input | 8 | Write data |
| link_state | input | 2 | 0 Active, 1 Dormant, 2 Re-Sync, 3 treated as Active |
| sub_mode | output | 3 | Effective sub-mode setting |
| disc_mode | output | 1 | Effective class: 0 normal, 1 disconnect |
| dormant_ok | output | 1 | Dormant entry permitted |
| pll_mult_sel | output | 3 | Effective multiplier code |
| lb_backward | output | 1 | Loop-back direction, 1 backward |
| lane_tx_en | output | 2 | Per-lane transmit enable, bit i for lane i |

## Verification
The assertions assume that `link_state` is a clean registered value that holds for whole cycles. They also assume that a write and an exit seen on the same edge resolve in the order stated above. The stimulus changes the link state and the write inputs only on falling edges, and it holds each Dormant or Re-Sync phase for at least one full cycle so that every exit is a single clean edge. Reserved multiplier codes, out-of-range mode codes and address 3 are all driven on purpose. A behavioural model then confirms that the assertion premises about ignored writes still hold.

// File: rtl/lt_tmode_pkg.sv
package lt_tmode_pkg;

  typedef enum logic [1:0] {
    LS_ACTIVE  = 2'd0,
    LS_DORMANT = 2'd1,
    LS_RESYNC  = 2'd2,
    LS_SPARE   = 2'd3
  } link_st_e;

  typedef enum logic [1:0] {
    WA_MODE  = 2'd0,
    WA_PARAM = 2'd1,
    WA_SUB   = 2'd2,
    WA_NONE  = 2'd3
  } wr_addr_e;

  // mode code bit meaning: bit0 = defer to Dormant exit, bit1 = disconnect class
  localparam int MC_DEFER_BIT = 0;
  localparam int MC_DISC_BIT  = 1;
  localparam int MC_NUM_CODES = 4;

endpackage

// File: rtl/lt_exit_det.sv
module lt_exit_det
  import lt_tmode_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  link_st_e link_state,
  output logic     dorm_exit,
  output logic     resync_exit,
  output logic     any_exit
);

  link_st_e prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= LS_ACTIVE;
    else        prev_q <= link_state;
  end

  always_comb begin
    dorm_exit   = (prev_q == LS_DORMANT) && (link_state != LS_DORMANT);
    resync_exit = (prev_q == LS_RESYNC)  && (link_state != LS_RESYNC);
    any_exit    = dorm_exit || resync_exit;
  end

  a_r3_exit_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(dorm_exit && resync_exit));

endmodule

// File: rtl/lt_mode_unit.sv
module lt_mode_unit
  import lt_tmode_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SUB_W   = 3,
  parameter int SUB_LSB = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mode,
  input  logic              wr_sub,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              dorm_exit,
  output logic [SUB_W-1:0]  eff_sub,
  output logic              eff_disc,
  output logic              dormant_ok
);

  logic [SUB_W-1:0] stage_q, sub_q, pend_sub_q;
  logic             disc_q, pend_disc_q, pend_q, dok_q;
  logic             code_ok, code_imm, code_def, code_disc;

  always_comb begin
    code_ok   = (wr_data < DATA_W'(MC_NUM_CODES));
    code_imm  = wr_mode && code_ok && !wr_data[MC_DEFER_BIT];
    code_def  = wr_mode && code_ok &&  wr_data[MC_DEFER_BIT];
    code_disc = wr_data[MC_DISC_BIT];
  end

  // staging register for the sub-mode field
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stage_q <= '0;
    else if (wr_sub) stage_q <= wr_data[SUB_LSB +: SUB_W];
  end

  // effective, pending and dormant permission; pending applied before new writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q       <= '0;
      disc_q      <= 1'b0;
      pend_q      <= 1'b0;
      pend_sub_q  <= '0;
      pend_disc_q <= 1'b0;
      dok_q       <= 1'b1;
    end else begin
      if (dorm_exit && pend_q) begin
        sub_q  <= pend_sub_q;
        disc_q <= pend_disc_q;
        pend_q <= 1'b0;
      end
      if (code_imm) begin
        sub_q  <= stage_q;
        disc_q <= code_disc;
        pend_q <= 1'b0;
        dok_q  <= !code_disc;
      end else if (code_def) begin
        pend_q      <= 1'b1;
        pend_sub_q  <= stage_q;
        pend_disc_q <= code_disc;
        dok_q       <= !code_disc;
      end
    end
  end

  assign eff_sub    = sub_q;
  assign eff_disc   = disc_q;
  assign dormant_ok = dok_q;

  a_r6_bad_code_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && (wr_data >= DATA_W'(MC_NUM_CODES)) && !dorm_exit)
      |=> ($stable(eff_sub) && $stable(eff_disc) && $stable(dormant_ok)));

  a_r4_dormant_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dormant_ok) |-> $past(wr_mode && (wr_data == DATA_W'(2) || wr_data == DATA_W'(3))));

  a_r3_change_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(eff_sub) || !$stable(eff_disc)) |-> ($past(wr_mode) || $past(dorm_exit)));

  a_r7_stage_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sub && !dorm_exit) |=> ($stable(eff_sub) && $stable(eff_disc)));

endmodule

// File: rtl/lt_pll_unit.sv
module lt_pll_unit #(
  parameter int MULT_W     = 3,
  parameter int MULT_LEGAL = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_param,
  input  logic [MULT_W-1:0] wr_mult,
  input  logic              any_exit,
  output logic [MULT_W-1:0] mult_sel
);

  logic [MULT_W-1:0] mult_q, pend_q;
  logic              pend_v_q, legal;

  assign legal = (wr_mult < MULT_W'(MULT_LEGAL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mult_q   <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else begin
      if (any_exit && pend_v_q) begin
        mult_q   <= pend_q;
        pend_v_q <= 1'b0;
      end
      if (wr_param && legal) begin
        pend_q   <= wr_mult;
        pend_v_q <= 1'b1;
      end
    end
  end

  assign mult_sel = mult_q;

  a_r8_mult_at_exit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mult_sel) |-> $past(any_exit));

  a_r9_mult_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mult_sel < MULT_W'(MULT_LEGAL));

endmodule

// File: rtl/lt_loop_unit.sv
module lt_loop_unit #(
  parameter int N_LANES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_param,
  input  logic               wr_dir,
  input  logic               any_exit,
  output logic               lb_dir,
  output logic [N_LANES-1:0] tx_en
);

  logic dir_q, turn_q, flip;

  assign flip = wr_param && (wr_dir != dir_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= 1'b0;
      turn_q <= 1'b0;
    end else begin
      if (any_exit && turn_q) turn_q <= 1'b0;
      if (flip) begin
        dir_q  <= wr_dir;
        turn_q <= 1'b1;
      end
    end
  end

  // lane 0 transmits in backward direction, every other lane in forward
  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    localparam logic LANE_DIR = (i == 0);
    logic tx_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  tx_q <= (LANE_DIR == 1'b0) && (i == 1);
      else if (flip)               tx_q <= 1'b0;
      else if (any_exit && turn_q) tx_q <= (dir_q == LANE_DIR) && (i < 2);
    end
    assign tx_en[i] = tx_q;
  end

  assign lb_dir = dir_q;

  a_r10_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lb_dir) |-> (tx_en == '0));

  a_r11_single_tx: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_en));

  a_r11_enable_at_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|tx_en) |-> $past(any_exit));

endmodule

// File: rtl/lt_tmode_ctrl.sv
module lt_tmode_ctrl
  import lt_tmode_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int SUB_W      = 3,
  parameter int SUB_LSB    = 1,
  parameter int MULT_W     = 3,
  parameter int MULT_LEGAL = 2,
  parameter int LB_BIT     = 7,
  parameter int N_LANES    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [1:0]         wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [1:0]         link_state,
  output logic [SUB_W-1:0]   sub_mode,
  output logic               disc_mode,
  output logic               dormant_ok,
  output logic [MULT_W-1:0]  pll_mult_sel,
  output logic               lb_backward,
  output logic [N_LANES-1:0] lane_tx_en
);

  logic     fire, wr_mode, wr_param, wr_sub;
  logic     dorm_exit, resync_exit, any_exit;
  wr_addr_e addr;

  assign wr_ready = 1'b1;
  assign fire     = wr_valid && wr_ready;
  assign addr     = wr_addr_e'(wr_addr);
  assign wr_mode  = fire && (addr == WA_MODE);
  assign wr_param = fire && (addr == WA_PARAM);
  assign wr_sub   = fire && (addr == WA_SUB);

  lt_exit_det u_exit (
    .clk         (clk),
    .rst_n       (rst_n),
    .link_state  (link_st_e'(link_state)),
    .dorm_exit   (dorm_exit),
    .resync_exit (resync_exit),
    .any_exit    (any_exit)
  );

  lt_mode_unit #(.DATA_W(DATA_W), .SUB_W(SUB_W), .SUB_LSB(SUB_LSB)) u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_mode    (wr_mode),
    .wr_sub     (wr_sub),
    .wr_data    (wr_data),
    .dorm_exit  (dorm_exit),
    .eff_sub    (sub_mode),
    .eff_disc   (disc_mode),
    .dormant_ok (dormant_ok)
  );

  lt_pll_unit #(.MULT_W(MULT_W), .MULT_LEGAL(MULT_LEGAL)) u_pll (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_param (wr_param),
    .wr_mult  (wr_data[MULT_W-1:0]),
    .any_exit (any_exit),
    .mult_sel (pll_mult_sel)
  );

  lt_loop_unit #(.N_LANES(N_LANES)) u_loop (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_param (wr_param),
    .wr_dir   (wr_data[LB_BIT]),
    .any_exit (any_exit),
    .lb_dir   (lb_backward),
    .tx_en    (lane_tx_en)
  );

  a_r12_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready);

  a_r12_null_write: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (addr == WA_NONE) && !any_exit)
      |=> ($stable(sub_mode) && $stable(disc_mode) && $stable(dormant_ok)
           && $stable(pll_mult_sel) && $stable(lb_backward) && $stable(lane_tx_en)));

endmodule

// File: tb/lt_tmode_ctrl_tb.sv
module lt_tmode_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] link_state = 2'd0;
  logic [2:0] sub_mode;
  logic       disc_mode, dormant_ok, lb_backward;
  logic [2:0] pll_mult_sel;
  logic [1:0] lane_tx_en;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lt_tmode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .link_state(link_state),
    .sub_mode(sub_mode), .disc_mode(disc_mode), .dormant_ok(dormant_ok),
    .pll_mult_sel(pll_mult_sel), .lb_backward(lb_backward), .lane_tx_en(lane_tx_en)
  );

  // behavioural reference model
  int m_sub, m_disc, m_dok, m_mult, m_dir, m_tx;
  int p_mode, p_sub, p_disc, p_mult_v, p_mult, p_turn, prev_ls, staged;

  task automatic model_reset();
    m_sub = 0; m_disc = 0; m_dok = 1; m_mult = 0; m_dir = 0; m_tx = 2;
    p_mode = 0; p_sub = 0; p_disc = 0; p_mult_v = 0; p_mult = 0; p_turn = 0;
    prev_ls = 0; staged = 0;
  endtask

  initial model_reset();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      int ls, d, f;
      bit dx, rx;
      ls = int'(link_state);
      dx = (prev_ls == 1) && (ls != 1);
      rx = (prev_ls == 2) && (ls != 2);
      if (dx && p_mode != 0) begin m_sub = p_sub; m_disc = p_disc; p_mode = 0; end
      if ((dx || rx) && p_mult_v != 0) begin m_mult = p_mult; p_mult_v = 0; end
      if ((dx || rx) && p_turn != 0) begin m_tx = (m_dir != 0) ? 1 : 2; p_turn = 0; end
      if (wr_valid) begin
        d = int'(wr_data);
        case (wr_addr)
          2'd0: begin
            if (d == 0 || d == 2) begin
              m_sub = staged; m_disc = d / 2; p_mode = 0; m_dok = (d == 0);
            end else if (d == 1 || d == 3) begin
              p_mode = 1; p_sub = staged; p_disc = d / 2; m_dok = (d == 1);
            end
          end
          2'd1: begin
            f = d % 8;
            if (f < 2) begin p_mult = f; p_mult_v = 1; end
            if ((d / 128) != m_dir) begin m_dir = d / 128; m_tx = 0; p_turn = 1; end
          end
          2'd2: staged = (d / 2) % 8;
          default: ;
        endcase
      end
      prev_ls = ls;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 model sub_mode", int'(sub_mode), m_sub);
      check("R4 model disc_mode", int'(disc_mode), m_disc);
      check("R5 model dormant_ok", int'(dormant_ok), m_dok);
      check("R8 model pll_mult_sel", int'(pll_mult_sel), m_mult);
      check("R10 model lb_backward", int'(lb_backward), m_dir);
      check("R11 model lane_tx_en", int'(lane_tx_en), m_tx);
      check("R12 model wr_ready", int'(wr_ready), 1);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic set_ls(input logic [1:0] v);
    @(negedge clk);
    link_state = v;
  endtask

  task automatic pass_through(input logic [1:0] st);
    set_ls(st);
    set_ls(2'd0);
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 sub_mode", int'(sub_mode), 0);
    check("R1 disc_mode", int'(disc_mode), 0);
    check("R1 dormant_ok", int'(dormant_ok), 1);
    check("R1 mult", int'(pll_mult_sel), 0);
    check("R1 lb_backward", int'(lb_backward), 0);
    check("R1 lane_tx_en", int'(lane_tx_en), 2);

    // R7 staging changes nothing
    wr(2'd2, 8'b1111_1010);
    check("R7 staged only", int'(sub_mode), 0);
    // R2 immediate normal
    wr(2'd0, 8'h00);
    check("R2 sub_mode", int'(sub_mode), 5);
    check("R2 dormant_ok", int'(dormant_ok), 1);
    // R4 immediate disconnect
    wr(2'd2, 8'hF4);
    wr(2'd0, 8'h02);
    check("R4 sub_mode", int'(sub_mode), 2);
    check("R4 disc_mode", int'(disc_mode), 1);
    check("R4 dormant_ok", int'(dormant_ok), 0);
    // R6 out-of-range codes
    wr(2'd0, 8'h07);
    wr(2'd0, 8'h40);
    check("R6 sub_mode kept", int'(sub_mode), 2);
    check("R6 dormant_ok kept", int'(dormant_ok), 0);
    // R3 deferred normal
    wr(2'd2, 8'h0E);
    wr(2'd0, 8'h01);
    check("R3 dormant_ok now", int'(dormant_ok), 1);
    check("R3 sub_mode held", int'(sub_mode), 2);
    pass_through(2'd2);
    check("R3 resync no apply", int'(sub_mode), 2);
    pass_through(2'd1);
    check("R3 dormant exit sub", int'(sub_mode), 7);
    check("R3 dormant exit class", int'(disc_mode), 0);
    // R5 deferred disconnect
    wr(2'd2, 8'h06);
    wr(2'd0, 8'h03);
    check("R5 dormant_ok now", int'(dormant_ok), 0);
    check("R5 sub_mode held", int'(sub_mode), 7);
    pass_through(2'd1);
    check("R5 applied sub", int'(sub_mode), 3);
    check("R5 applied class", int'(disc_mode), 1);
    // R8 multiplier deferral
    wr(2'd1, 8'h01);
    check("R8 held", int'(pll_mult_sel), 0);
    pass_through(2'd2);
    check("R8 resync exit", int'(pll_mult_sel), 1);
    // R9 reserved ignored
    wr(2'd1, 8'h05);
    pass_through(2'd1);
    check("R9 reserved kept", int'(pll_mult_sel), 1);
    wr(2'd1, 8'h00);
    pass_through(2'd1);
    check("R8 back to x15", int'(pll_mult_sel), 0);
    // R10 turnaround
    wr(2'd1, 8'h80);
    check("R10 lb_backward", int'(lb_backward), 1);
    check("R10 lanes input", int'(lane_tx_en), 0);
    repeat (3) @(negedge clk);
    check("R11 still input", int'(lane_tx_en), 0);
    pass_through(2'd2);
    check("R11 backward tx", int'(lane_tx_en), 1);
    wr(2'd1, 8'h80);
    check("R10 same dir no effect", int'(lane_tx_en), 1);
    wr(2'd1, 8'h00);
    check("R10 forward lanes input", int'(lane_tx_en), 0);
    pass_through(2'd1);
    check("R11 forward tx", int'(lane_tx_en), 2);
    // R12 null address
    wr(2'd3, 8'hFF);
    check("R12 ready", int'(wr_ready), 1);
    check("R12 null sub", int'(sub_mode), 3);
    check("R12 null dir", int'(lb_backward), 0);
    check("R12 null mult", int'(pll_mult_sel), 0);
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule